// File: doc/BRIEF.md
# Resident Page Map with Least-Recently-Used Frame Replacement

This block translates virtual page numbers into physical frame numbers for a memory hierarchy model. Each request carries one virtual page number. One clock later the block answers with a hit and the frame holding that page, or with a fault. On a fault the page is made resident in a frame, and the answer returns that frame.

Frames are handed out in strictly ascending order, starting at frame 0, until every frame holds a page. After that, each fault reuses the frame that was touched least recently. A hit or a fill counts as a touch. When a fault displaces a resident page, the block raises an eviction event for that cycle. The event carries the displaced virtual page and its frame, so the translation buffer and both cache levels can drop their entries for that frame. Three running counters record table consultations, faults and disk transfers, where each fault counts as one transfer.

The surrounding logic presents a request only when a translation-buffer lookup misses, or on every access when there is no translation buffer.

Top module: `page_table_lru`

## Requirements
- R1: While reset is held, and after its release until the first request, `resp_valid` and `evict_valid` are 0, all three counters read 0, and no virtual page is resident.
- R2: A request accepted at a clock edge (`req_valid`=1) produces `resp_valid`=1 on the outputs after the next edge, and `resp_valid` is 0 after every other edge.
- R3: A request for a resident page gives `resp_hit`=1, with `resp_pfn` equal to the frame the page was placed in.
- R4: While unused frames remain, the k-th fault after reset (counting from 0) gives `resp_hit`=0 and `resp_pfn`=k, with `evict_valid`=0.
- R5: Once every frame is in use, a fault takes the frame whose last hit or fill is the oldest.
- R6: A fault that displaces a page sets `evict_valid`=1, with `evict_vpn` set to the displaced page and `evict_pfn` equal to `resp_pfn`. The displaced page misses on its next request.
- R7: Each request adds 1 to `cnt_pt_refs`. Each fault adds 1 to `cnt_faults` and 1 to `cnt_disk`. A hit leaves both of those counters unchanged.
- R8: A cycle with `req_valid`=0 produces no response and no eviction, and leaves every counter and every mapping unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| resp_valid | output | 1 | Response strobe, one cycle after the request |
| resp_hit | output | 1 | 1 = page was resident, 0 = fault |
| resp_pfn | output | PFN_W | Frame now holding the page |
| evict_valid | output | 1 | A resident page was displaced by this fault |
| evict_vpn | output | VPN_W | Displaced virtual page |
| evict_pfn | output | PFN_W | Frame of the displaced page, to invalidate downstream |
| cnt_pt_refs | output | CNT_W | Table consultations |
| cnt_faults | output | CNT_W | Page faults |
| cnt_disk | output | CNT_W | Disk transfers |

## Verification
The assertions assume that `req_valid` and `req_vpn` are never unknown after reset. They also assume the counters never wrap. The bench drives inputs on the falling edge with defined values at all times, and its runs stay far below the counter width. A reference model in the bench uses per-frame timestamps instead of ranks. The stimulus covers three patterns: a sweep over every virtual page, a short repeated working set that mixes hits and replacements, and pseudo-random page streams.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned PT_VPN_W_DEF = 6;
  localparam int unsigned PT_PFN_W_DEF = 2;
  localparam int unsigned PT_CNT_W_DEF = 32;

  typedef enum logic [1:0] {
    ACC_NONE    = 2'd0,
    ACC_HIT     = 2'd1,
    ACC_FILL    = 2'd2,
    ACC_REPLACE = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/pt_vpn_map.sv
module pt_vpn_map #(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PFN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] rd_vpn,
  output logic             rd_valid,
  output logic [PFN_W-1:0] rd_pfn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             clr_en,
  input  logic [VPN_W-1:0] clr_vpn
);
  localparam int unsigned NPAGES = 1 << VPN_W;

  logic [NPAGES-1:0] valid_q;
  logic [PFN_W-1:0]  pfn_q [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_entry
    logic set_hit;
    logic clr_hit;
    assign set_hit = wr_en  && (wr_vpn  == VPN_W'(g));
    assign clr_hit = clr_en && (clr_vpn == VPN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (set_hit) begin
        valid_q[g] <= 1'b1;
      end else if (clr_hit) begin
        valid_q[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (set_hit) begin
        pfn_q[g] <= wr_pfn;
      end
    end
  end

  assign rd_valid = valid_q[rd_vpn];
  assign rd_pfn   = pfn_q[rd_vpn];
endmodule

// File: rtl/pt_frame_lru.sv
module pt_frame_lru #(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PFN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [PFN_W-1:0] touch_pfn,
  input  logic             alloc_en,
  input  logic [VPN_W-1:0] alloc_vpn,
  output logic [PFN_W-1:0] alloc_pfn,
  output logic             alloc_replace,
  output logic [VPN_W-1:0] victim_vpn
);
  localparam int unsigned NFRAMES = 1 << PFN_W;
  localparam int unsigned FILL_W  = PFN_W + 1;

  logic [PFN_W-1:0] rank_q  [NFRAMES];
  logic [VPN_W-1:0] owner_q [NFRAMES];
  logic [FILL_W-1:0] fill_q;
  logic [FILL_W-1:0] fill_d;
  logic              full;
  logic [PFN_W-1:0]  lru_pfn;
  logic [PFN_W-1:0]  touch_rank;

  assign full = (fill_q == FILL_W'(NFRAMES));

  always_comb begin
    lru_pfn = '0;
    for (int i = 0; i < NFRAMES; i++) begin
      if (rank_q[i] == PFN_W'(NFRAMES - 1)) begin
        lru_pfn = PFN_W'(i);
      end
    end
  end

  assign alloc_replace = full;
  assign alloc_pfn     = full ? lru_pfn : fill_q[PFN_W-1:0];
  assign victim_vpn    = owner_q[lru_pfn];
  assign touch_rank    = rank_q[touch_pfn];

  always_comb begin
    fill_d = fill_q;
    if (alloc_en && !full) begin
      fill_d = fill_q + FILL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (alloc_en) begin
      fill_q <= fill_d;
    end
  end

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    logic [PFN_W-1:0] rank_d;
    always_comb begin
      rank_d = rank_q[g];
      if (touch_pfn == PFN_W'(g)) begin
        rank_d = '0;
      end else if (rank_q[g] < touch_rank) begin
        rank_d = rank_q[g] + PFN_W'(1);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rank_q[g] <= PFN_W'(g);
      end else if (touch_en) begin
        rank_q[g] <= rank_d;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && (alloc_pfn == PFN_W'(g))) begin
        owner_q[g] <= alloc_vpn;
      end
    end
  end
endmodule

// File: rtl/pt_counters.sv
module pt_counters #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic             fault_en,
  output logic [CNT_W-1:0] refs,
  output logic [CNT_W-1:0] faults,
  output logic [CNT_W-1:0] disk
);
  logic [CNT_W-1:0] refs_d, faults_d, disk_d;

  always_comb begin
    refs_d   = refs + CNT_W'(1);
    faults_d = faults + CNT_W'(1);
    disk_d   = disk + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refs <= '0;
    end else if (ref_en) begin
      refs <= refs_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faults <= '0;
      disk   <= '0;
    end else if (fault_en) begin
      faults <= faults_d;
      disk   <= disk_d;
    end
  end
endmodule

// File: rtl/page_table_lru.sv
module page_table_lru
  import pt_pkg::*;
#(
  parameter int unsigned VPN_W = PT_VPN_W_DEF,
  parameter int unsigned PFN_W = PT_PFN_W_DEF,
  parameter int unsigned CNT_W = PT_CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VPN_W-1:0] req_vpn,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic [PFN_W-1:0] resp_pfn,
  output logic             evict_valid,
  output logic [VPN_W-1:0] evict_vpn,
  output logic [PFN_W-1:0] evict_pfn,
  output logic [CNT_W-1:0] cnt_pt_refs,
  output logic [CNT_W-1:0] cnt_faults,
  output logic [CNT_W-1:0] cnt_disk
);
  logic             map_valid;
  logic [PFN_W-1:0] map_pfn;
  logic [PFN_W-1:0] alloc_pfn;
  logic             alloc_replace;
  logic [VPN_W-1:0] victim_vpn;
  logic             fault;
  logic [PFN_W-1:0] use_pfn;
  acc_kind_e        kind;

  logic             resp_valid_d, resp_hit_d, evict_valid_d;
  logic [PFN_W-1:0] resp_pfn_d;
  logic [VPN_W-1:0] evict_vpn_d;

  always_comb begin
    kind = ACC_NONE;
    if (req_valid) begin
      if (map_valid)          kind = ACC_HIT;
      else if (alloc_replace) kind = ACC_REPLACE;
      else                    kind = ACC_FILL;
    end
  end

  assign fault   = (kind == ACC_FILL) || (kind == ACC_REPLACE);
  assign use_pfn = (kind == ACC_HIT) ? map_pfn : alloc_pfn;

  pt_vpn_map #(.VPN_W(VPN_W), .PFN_W(PFN_W)) map_i (
    .clk(clk), .rst_n(rst_n),
    .rd_vpn(req_vpn), .rd_valid(map_valid), .rd_pfn(map_pfn),
    .wr_en(fault), .wr_vpn(req_vpn), .wr_pfn(alloc_pfn),
    .clr_en(kind == ACC_REPLACE), .clr_vpn(victim_vpn)
  );

  pt_frame_lru #(.VPN_W(VPN_W), .PFN_W(PFN_W)) lru_i (
    .clk(clk), .rst_n(rst_n),
    .touch_en(req_valid), .touch_pfn(use_pfn),
    .alloc_en(fault), .alloc_vpn(req_vpn),
    .alloc_pfn(alloc_pfn), .alloc_replace(alloc_replace),
    .victim_vpn(victim_vpn)
  );

  pt_counters #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n),
    .ref_en(req_valid), .fault_en(fault),
    .refs(cnt_pt_refs), .faults(cnt_faults), .disk(cnt_disk)
  );

  always_comb begin
    resp_valid_d  = req_valid;
    resp_hit_d    = (kind == ACC_HIT);
    resp_pfn_d    = use_pfn;
    evict_valid_d = (kind == ACC_REPLACE);
    evict_vpn_d   = victim_vpn;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid  <= 1'b0;
      resp_hit    <= 1'b0;
      resp_pfn    <= '0;
      evict_valid <= 1'b0;
      evict_vpn   <= '0;
      evict_pfn   <= '0;
    end else begin
      resp_valid  <= resp_valid_d;
      evict_valid <= evict_valid_d;
      if (req_valid) begin
        resp_hit  <= resp_hit_d;
        resp_pfn  <= resp_pfn_d;
        evict_vpn <= evict_vpn_d;
        evict_pfn <= resp_pfn_d;
      end
    end
  end
endmodule

// File: rtl/pt_checker.sv
module pt_checker #(
  parameter int unsigned VPN_W = 6,
  parameter int unsigned PFN_W = 2,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [PFN_W-1:0] resp_pfn,
  input logic             evict_valid,
  input logic [PFN_W-1:0] evict_pfn,
  input logic [CNT_W-1:0] cnt_pt_refs,
  input logic [CNT_W-1:0] cnt_faults,
  input logic [CNT_W-1:0] cnt_disk
);
  logic seen_edge;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (resp_valid == $past(req_valid))) else $error("resp timing"); // R2
  AST_EVICT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    evict_valid |-> (resp_valid && !resp_hit && evict_pfn == resp_pfn)) else $error("evict"); // R6
  AST_REF_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && resp_valid) |-> (cnt_pt_refs == $past(cnt_pt_refs) + CNT_W'(1))) else $error("refs"); // R7
  AST_FAULT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && resp_valid && !resp_hit) |-> (cnt_faults == $past(cnt_faults) + CNT_W'(1))) else $error("faults"); // R7
  AST_HIT_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && resp_valid && resp_hit) |-> $stable(cnt_faults)) else $error("hit counted"); // R7
  AST_DISK_TRACKS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_disk == cnt_faults) else $error("disk"); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && !resp_valid) |-> ($stable(cnt_pt_refs) && !evict_valid)) else $error("idle"); // R8
endmodule

bind page_table_lru pt_checker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
  .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pfn(resp_pfn),
  .evict_valid(evict_valid), .evict_pfn(evict_pfn),
  .cnt_pt_refs(cnt_pt_refs), .cnt_faults(cnt_faults), .cnt_disk(cnt_disk)
);

// File: tb/page_table_lru_tb_top.sv
module page_table_lru_tb_top;
  localparam int VPN_W    = 6;
  localparam int PFN_W    = 2;
  localparam int CNT_W    = 32;
  localparam int NPAGES   = 1 << VPN_W;
  localparam int NFRAMES  = 1 << PFN_W;
  localparam time CLK_PERIOD = 10ns;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [VPN_W-1:0] req_vpn;
  logic             resp_valid, resp_hit, evict_valid;
  logic [PFN_W-1:0] resp_pfn, evict_pfn;
  logic [VPN_W-1:0] evict_vpn;
  logic [CNT_W-1:0] cnt_pt_refs, cnt_faults, cnt_disk;

  page_table_lru #(.VPN_W(VPN_W), .PFN_W(PFN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_pfn(resp_pfn),
    .evict_valid(evict_valid), .evict_vpn(evict_vpn), .evict_pfn(evict_pfn),
    .cnt_pt_refs(cnt_pt_refs), .cnt_faults(cnt_faults), .cnt_disk(cnt_disk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Reference model: per-frame timestamps of last use
  bit m_valid [NPAGES];
  int m_pfn   [NPAGES];
  int m_owner [NFRAMES];
  int m_last  [NFRAMES];
  int m_fill  = 0;
  int m_time  = 0;
  int m_refs  = 0;
  int m_faults = 0;

  task automatic check(input string req, input bit ok, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic access(input int v);
    bit e_hit, e_ev;
    int f, e_evv;
    string tag;
    m_time++;
    e_ev = 0; e_evv = 0;
    m_refs++;
    if (m_valid[v]) begin
      e_hit = 1; f = m_pfn[v]; tag = "R3";
    end else begin
      e_hit = 0; m_faults++;
      if (m_fill < NFRAMES) begin
        f = m_fill; m_fill++; tag = "R4";
      end else begin
        f = 0;
        for (int i = 1; i < NFRAMES; i++) if (m_last[i] < m_last[f]) f = i;
        e_ev = 1; e_evv = m_owner[f]; m_valid[e_evv] = 0; tag = "R5";
      end
      m_owner[f] = v; m_valid[v] = 1; m_pfn[v] = f;
    end
    m_last[f] = m_time;

    @(negedge clk);
    req_valid = 1'b1;
    req_vpn   = VPN_W'(v);
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", resp_valid === 1'b1, "resp_valid", resp_valid, 1);
    check(tag, resp_hit === e_hit, "resp_hit", resp_hit, e_hit);
    check(tag, resp_pfn === PFN_W'(f), "resp_pfn", resp_pfn, f);
    check("R6", evict_valid === e_ev, "evict_valid", evict_valid, e_ev);
    if (e_ev) begin
      check("R6", evict_vpn === VPN_W'(e_evv), "evict_vpn", evict_vpn, e_evv);
      check("R6", evict_pfn === PFN_W'(f), "evict_pfn", evict_pfn, f);
    end
    check("R7", cnt_pt_refs == CNT_W'(m_refs), "cnt_pt_refs", cnt_pt_refs, m_refs);
    check("R7", cnt_faults == CNT_W'(m_faults), "cnt_faults", cnt_faults, m_faults);
    check("R7", cnt_disk == CNT_W'(m_faults), "cnt_disk", cnt_disk, m_faults);
  endtask

  task automatic idle_check();
    @(negedge clk);
    req_vpn = VPN_W'(NPAGES - 1);
    @(negedge clk);
    check("R8", resp_valid === 1'b0, "resp_valid idle", resp_valid, 0);
    check("R8", evict_valid === 1'b0, "evict_valid idle", evict_valid, 0);
    check("R8", cnt_pt_refs == CNT_W'(m_refs), "refs idle", cnt_pt_refs, m_refs);
    check("R8", cnt_faults == CNT_W'(m_faults), "faults idle", cnt_faults, m_faults);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < NPAGES; i++) begin m_valid[i] = 0; m_pfn[i] = 0; end
    for (int i = 0; i < NFRAMES; i++) begin m_owner[i] = 0; m_last[i] = 0; end
    rst_n = 1'b0; req_valid = 1'b0; req_vpn = '0;
    repeat (3) @(negedge clk);
    // R1: state under reset
    check("R1", resp_valid === 1'b0, "resp_valid in reset", resp_valid, 0);
    check("R1", evict_valid === 1'b0, "evict_valid in reset", evict_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cnt_pt_refs == 0 && cnt_faults == 0 && cnt_disk == 0,
          "counters after reset", cnt_pt_refs + cnt_faults + cnt_disk, 0);
    check("R1", resp_valid === 1'b0, "resp_valid after reset", resp_valid, 0);

    // Working set C,8,1,C,4,1,C,0: frames 0,1,2,hit0,3,hit2,hit0, then 0 displaces 8 in frame 1
    access(12); access(8); access(1); access(12);
    access(4); access(1); access(12); access(0);
    check("R5", resp_pfn === PFN_W'(1), "page 0 frame", resp_pfn, 1);
    check("R6", evict_vpn === VPN_W'(8), "displaced page", evict_vpn, 8);
    access(8); // R6: displaced page misses again
    idle_check();

    // Sweep every page twice, then repeated small working set
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < NPAGES; v++) access(v);
    for (int r = 0; r < 40; r++)
      for (int v = 0; v < NFRAMES + 1; v++) access((v * 3 + r) % (NFRAMES + 2));
    idle_check();

    // Pseudo-random streams, narrow and wide
    seed = 7;
    for (int k = 0; k < 600; k++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      access((k < 300) ? ((seed >> 8) % 6) : ((seed >> 8) % NPAGES));
    end
    idle_check();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule